// File: doc/BRIEF.md
# Password-Guarded Clock Policy Controller

This block is the register bank of a clock-control unit. Software reaches it through a plain 32-bit word-addressed read/write bus. The bus reads back combinationally and writes on the clock edge. A password-keyed access register must be opened before any other register accepts a write. Four clock-enable masks are held, one per power policy, numbered 0 (lowest power) to 3. Bit k of every mask controls the same clock k.

A small policy engine commits a chosen policy to the 32-bit clock-enable output. Software writes the control word with the go bit set, picks either the synchronous or the background-copy mode, and then polls go until it reads 0. The stabilisation wait is a fixed number of cycles set by a parameter. The engine can be stopped through a separate stop register, and a stopped engine is the only state in which the masks may be rewritten. A new go restarts it. The output only changes when the engine commits, so mask edits never disturb the running clocks.

Top module: `cpol_regctl`

## Requirements
- R1: After reset: access word (0) reads 0, all four masks read 0xFFFFFFFF, control (5) reads 0x200, stop word (6) reads 0x2, `clk_en_o` is 0xFFFFFFFF and `active_pol_o` is 2.
- R2: A write to word 0 whose bits [31:8] equal 0x00A5A5 sets the write-enable state to bit 0 of the data (1 opens, 0 closes), and word 0 bit 0 reads that state. A write to word 0 with any other value in bits [31:8] is ignored.
- R3: While writes are closed, writes to words 1 to 7 are ignored.
- R4: A control write with bit 0 (go) set while go reads 0 starts the engine. Go then reads 1 for exactly STAB_CYCLES cycles after the write edge and reads 0 afterwards. Any control write made while go reads 1 is ignored.
- R5: With control bit 1 (sync) set, the policy in bits [9:8] and its mask reach `active_pol_o` and `clk_en_o` in the cycle after the go write, while go still reads 1.
- R6: With bit 1 clear and bit 2 (copy) set, the output keeps the old policy while busy, and the new policy and mask appear on the same edge at which go clears.
- R7: With go set and both bit 1 and bit 2 clear, the output does not change and go still clears after STAB_CYCLES.
- R8: The control word is replaced whole by each accepted write. Bits 1, 2 and [9:8] read back as written, bit 0 reads the busy state, and all other bits read 0.
- R9: Masks for policies 0 to 3 sit at words 1 to 4. A mask write is accepted only while writes are open and the engine is stopped. A mask write never changes `clk_en_o`, which changes only when the engine commits.
- R10: Writing 1 to bit 0 of word 6 requests a stop. Bit 0 reads 1 until the engine has stopped, and bit 1 reads 1 while the engine runs. A request made while go reads 1 is held until go clears, and the engine stops on the following edge. An accepted go restarts the engine.
- R11: Word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_en_o | output | 32 | Clock-enable mask of the committed policy |
| active_pol_o | output | POL_W (2) | Committed policy number |

## Verification
The interesting overlap is a stop request that lands while a synchronous commit is still counting. In the same clock, the engine retires its go bit and sees the pending stop. The bench issues the stop one cycle after go and polls the stop word on every cycle. The stop bit must stay 1 through the cycle in which go clears, and it must drop together with the running bit exactly one cycle later. A mask write made afterwards must then be accepted without moving the clock-enable output.

// File: rtl/cpol_pkg.sv
`timescale 1ns/1ps
package cpol_pkg;
    localparam logic [23:0] ACCESS_KEY = 24'h00A5A5;
    localparam int GO_BIT   = 0;
    localparam int SYNC_BIT = 1;
    localparam int COPY_BIT = 2;
    localparam int POL_LSB  = 8;
    localparam int STOP_BIT = 0;
    localparam int RUN_BIT  = 1;
endpackage

// File: rtl/cpol_lock.sv
`timescale 1ns/1ps
module cpol_lock import cpol_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [23:0] key_i,
    input  logic        open_i,
    output logic        unlocked_o
);
    typedef struct packed {
        logic unlocked;
    } lock_t;

    lock_t lk_d, lk_q;
    logic  key_ok;

    assign key_ok = (key_i == ACCESS_KEY);

    always_comb begin
        lk_d = lk_q;
        if (wr_i && key_ok) lk_d.unlocked = open_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign unlocked_o = lk_q.unlocked;

    assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !key_ok) |=> $stable(unlocked_o));
endmodule

// File: rtl/cpol_engine.sv
`timescale 1ns/1ps
module cpol_engine #(
    parameter  int POL_W       = 2,
    parameter  int STAB_CYCLES = 4,
    parameter  int RST_POL     = 2,
    localparam int CNT_W       = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic             go_i,
    input  logic             sync_i,
    input  logic             copy_i,
    input  logic [POL_W-1:0] pol_i,
    input  logic             stop_wr_i,
    output logic             busy_o,
    output logic             running_o,
    output logic             stop_pend_o,
    output logic             sync_o,
    output logic             copy_o,
    output logic [POL_W-1:0] pol_o,
    output logic             commit_o,
    output logic [POL_W-1:0] commit_pol_o
);
    typedef struct packed {
        logic             busy;
        logic             running;
        logic             stop_pend;
        logic             sync;
        logic             copy;
        logic [POL_W-1:0] pol;
        logic [CNT_W-1:0] cnt;
    } eng_t;

    eng_t eg_d, eg_q;

    always_comb begin
        eg_d         = eg_q;
        commit_o     = 1'b0;
        commit_pol_o = eg_q.pol;
        // stop retires first, so a go in the same cycle restarts the engine
        if (eg_q.stop_pend && !eg_q.busy) begin
            eg_d.stop_pend = 1'b0;
            eg_d.running   = 1'b0;
        end
        if (stop_wr_i) eg_d.stop_pend = 1'b1;
        if (eg_q.busy) begin
            if (eg_q.cnt == '0) begin
                eg_d.busy = 1'b0;
                if (!eg_q.sync && eg_q.copy) commit_o = 1'b1;
            end else begin
                eg_d.cnt = eg_q.cnt - 1'b1;
            end
        end else if (ctrl_wr_i) begin
            eg_d.sync = sync_i;
            eg_d.copy = copy_i;
            eg_d.pol  = pol_i;
            if (go_i) begin
                eg_d.busy    = 1'b1;
                eg_d.running = 1'b1;
                eg_d.cnt     = CNT_W'(STAB_CYCLES - 1);
                if (sync_i) begin
                    commit_o     = 1'b1;
                    commit_pol_o = pol_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eg_q         <= '0;
            eg_q.running <= 1'b1;
            eg_q.pol     <= POL_W'(RST_POL);
        end else begin
            eg_q <= eg_d;
        end
    end

    assign busy_o      = eg_q.busy;
    assign running_o   = eg_q.running;
    assign stop_pend_o = eg_q.stop_pend;
    assign sync_o      = eg_q.sync;
    assign copy_o      = eg_q.copy;
    assign pol_o       = eg_q.pol;

    assert_go_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && go_i && !busy_o) |=> busy_o);
    assert_busy_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> running_o);
    assert_stop_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend_o && busy_o) |=> (running_o && stop_pend_o));
    assert_stop_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend_o && !busy_o && !stop_wr_i) |=> !stop_pend_o);
endmodule

// File: rtl/cpol_regctl.sv
`timescale 1ns/1ps
module cpol_regctl import cpol_pkg::*; #(
    parameter  int NUM_POL     = 4,
    parameter  int STAB_CYCLES = 4,
    parameter  int RST_POL     = 2,
    localparam int POL_W       = (NUM_POL > 1) ? $clog2(NUM_POL) : 1,
    localparam int ADDR_W      = $clog2(NUM_POL + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       clk_en_o,
    output logic [POL_W-1:0]  active_pol_o
);
    localparam int CTRL_ADDR = NUM_POL + 1;
    localparam int STOP_ADDR = NUM_POL + 2;

    typedef struct packed {
        logic [NUM_POL-1:0][31:0] masks;
        logic [POL_W-1:0]         act_pol;
        logic [31:0]              act_mask;
    } bank_t;

    bank_t rb_d, rb_q;

    logic               wr, prot_wr, acc_wr, ctrl_wr, stop_wr, unlocked;
    logic [NUM_POL-1:0] mask_sel;
    logic               busy, running, stop_pend, sync_l, copy_l, commit;
    logic [POL_W-1:0]   pol_l, commit_pol;

    assign wr      = bus_en && bus_we;
    assign prot_wr = wr && unlocked;
    assign acc_wr  = wr && (bus_addr == '0);
    assign ctrl_wr = prot_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign stop_wr = prot_wr && (bus_addr == ADDR_W'(STOP_ADDR)) && bus_wdata[STOP_BIT];

    for (genvar p = 0; p < NUM_POL; p++) begin : g_sel
        assign mask_sel[p] = (bus_addr == ADDR_W'(p + 1));
    end

    cpol_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (acc_wr),
        .key_i      (bus_wdata[31:8]),
        .open_i     (bus_wdata[0]),
        .unlocked_o (unlocked)
    );

    cpol_engine #(
        .POL_W       (POL_W),
        .STAB_CYCLES (STAB_CYCLES),
        .RST_POL     (RST_POL)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_i    (ctrl_wr),
        .go_i         (bus_wdata[GO_BIT]),
        .sync_i       (bus_wdata[SYNC_BIT]),
        .copy_i       (bus_wdata[COPY_BIT]),
        .pol_i        (bus_wdata[POL_LSB +: POL_W]),
        .stop_wr_i    (stop_wr),
        .busy_o       (busy),
        .running_o    (running),
        .stop_pend_o  (stop_pend),
        .sync_o       (sync_l),
        .copy_o       (copy_l),
        .pol_o        (pol_l),
        .commit_o     (commit),
        .commit_pol_o (commit_pol)
    );

    always_comb begin
        rb_d = rb_q;
        for (int p = 0; p < NUM_POL; p++) begin
            if (prot_wr && !running && mask_sel[p]) rb_d.masks[p] = bus_wdata;
        end
        if (commit) begin
            rb_d.act_pol  = commit_pol;
            rb_d.act_mask = rb_q.masks[commit_pol];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q.masks    <= '1;
            rb_q.act_mask <= '1;
            rb_q.act_pol  <= POL_W'(RST_POL);
        end else begin
            rb_q <= rb_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata[0] = unlocked;
        for (int p = 0; p < NUM_POL; p++) begin
            if (mask_sel[p]) bus_rdata = rb_q.masks[p];
        end
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata[GO_BIT]            = busy;
            bus_rdata[SYNC_BIT]          = sync_l;
            bus_rdata[COPY_BIT]          = copy_l;
            bus_rdata[POL_LSB +: POL_W]  = pol_l;
        end
        if (bus_addr == ADDR_W'(STOP_ADDR)) begin
            bus_rdata[STOP_BIT] = stop_pend;
            bus_rdata[RUN_BIT]  = running;
        end
    end

    assign clk_en_o     = rb_q.act_mask;
    assign active_pol_o = rb_q.act_pol;

    assert_locked_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !unlocked && bus_addr != '0) |=> $stable(rb_q.masks));
    assert_mask_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && running) |=> $stable(rb_q.masks));
    assert_clken_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(clk_en_o) && $stable(active_pol_o)));
endmodule

// File: tb/cpol_regctl_bench.sv
`timescale 1ns/1ps
module cpol_regctl_bench;
    localparam int S = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] clk_en_o;
    logic [1:0]  active_pol_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_mask [4];
    logic        m_open;

    always #4 clk = ~clk;

    cpol_regctl u_cpol_regctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_en       (bus_en),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .clk_en_o     (clk_en_o),
        .active_pol_o (active_pol_o)
    );

    function automatic logic [31:0] key_word(input logic open);
        return {24'h00A5A5, 7'd0, open};
    endfunction

    function automatic logic [31:0] ctrl_word(input logic go, input logic sync,
                                              input logic copy, input logic [1:0] pol);
        return {22'd0, pol, 5'd0, copy, sync, go};
    endfunction

    function automatic logic [31:0] stop_word(input logic pend, input logic run);
        return {30'd0, run, pend};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk_rd("R1 access", 3'd0, 32'h0);
        for (int p = 0; p < 4; p++) chk_rd("R1 mask", 3'(p + 1), 32'hFFFF_FFFF);
        chk_rd("R1 ctrl", 3'd5, ctrl_word(0, 0, 0, 2'd2));
        chk_rd("R1 stop", 3'd6, stop_word(0, 1));
        check("R1 clk_en", clk_en_o, 32'hFFFF_FFFF);
        check("R1 pol", {30'd0, active_pol_o}, 32'd2);
        chk_rd("R11 unmapped", 3'd7, 32'h0);

        // R3 locked writes ignored
        wr(3'd2, 32'h1234_5678);
        chk_rd("R3 locked mask", 3'd2, 32'hFFFF_FFFF);
        wr(3'd6, 32'h1);
        chk_rd("R3 locked stop", 3'd6, stop_word(0, 1));
        wr(3'd5, ctrl_word(1, 1, 0, 2'd0));
        chk_rd("R3 locked ctrl", 3'd5, ctrl_word(0, 0, 0, 2'd2));

        // R2 password
        wr(3'd0, 32'h00A5_A401);
        chk_rd("R2 bad key", 3'd0, 32'h0);
        wr(3'd0, key_word(1));
        chk_rd("R2 open", 3'd0, 32'h1);
        wr(3'd0, 32'h01A5_A500);
        chk_rd("R2 bad close", 3'd0, 32'h1);

        // R9 mask write while running is ignored
        wr(3'd1, 32'h0BAD_0BAD);
        chk_rd("R9 running mask", 3'd1, 32'hFFFF_FFFF);

        // R10 stop while idle
        wr(3'd6, 32'h1);
        chk_rd("R10 stop pending", 3'd6, stop_word(1, 1));
        tick(1);
        chk_rd("R10 stopped", 3'd6, stop_word(0, 0));

        // random mask and lock traffic, engine stopped
        m_open = 1'b1;
        for (int p = 0; p < 4; p++) m_mask[p] = 32'hFFFF_FFFF;
        for (int i = 0; i < 60; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            if (op == 0) begin
                wr(3'd0, key_word(1)); m_open = 1'b1;
            end else if (op == 1) begin
                wr(3'd0, key_word(0)); m_open = 1'b0;
            end else if (op == 2) begin
                logic [31:0] bad;
                bad = $urandom();
                if (bad[31:8] == 24'h00A5A5) bad[31] = 1'b1;
                wr(3'd0, bad);
            end else begin
                int idx;
                logic [31:0] d;
                idx = int'($urandom_range(0, 3));
                d = $urandom();
                wr(3'(idx + 1), d);
                if (m_open) m_mask[idx] = d;
            end
            chk_rd("R2 random access", 3'd0, {31'd0, m_open});
            begin
                int q;
                q = int'($urandom_range(0, 3));
                chk_rd(m_open ? "R9 random mask" : "R3 random mask", 3'(q + 1), m_mask[q]);
            end
        end
        check("R9 clk_en untouched", clk_en_o, 32'hFFFF_FFFF);

        // directed masks
        wr(3'd0, key_word(1));
        m_mask[0] = 32'h0000_000F; m_mask[1] = 32'h0000_00F0;
        m_mask[2] = 32'h0000_0F00; m_mask[3] = 32'h0000_F000;
        for (int p = 0; p < 4; p++) wr(3'(p + 1), m_mask[p]);
        check("R9 clk_en after writes", clk_en_o, 32'hFFFF_FFFF);

        // R5 sync commit to policy 1, R4 busy window and ignored write
        wr(3'd5, ctrl_word(1, 1, 0, 2'd1));
        check("R5 sync clk_en", clk_en_o, m_mask[1]);
        check("R5 sync pol", {30'd0, active_pol_o}, 32'd1);
        chk_rd("R8 ctrl busy", 3'd5, ctrl_word(1, 1, 0, 2'd1));
        chk_rd("R10 go restarts", 3'd6, stop_word(0, 1));
        wr(3'd5, ctrl_word(1, 0, 1, 2'd3));
        chk_rd("R4 write while busy", 3'd5, ctrl_word(1, 1, 0, 2'd1));
        tick(S - 2);
        chk_rd("R4 last busy cycle", 3'd5, ctrl_word(1, 1, 0, 2'd1));
        tick(1);
        chk_rd("R4 go cleared", 3'd5, ctrl_word(0, 1, 0, 2'd1));
        check("R4 pol stays", {30'd0, active_pol_o}, 32'd1);

        // R6 background copy to policy 3
        wr(3'd5, ctrl_word(1, 0, 1, 2'd3));
        check("R6 old while busy", clk_en_o, m_mask[1]);
        tick(S - 1);
        check("R6 old on last busy", clk_en_o, m_mask[1]);
        chk_rd("R6 still busy", 3'd5, ctrl_word(1, 0, 1, 2'd3));
        tick(1);
        check("R6 copied", clk_en_o, m_mask[3]);
        check("R6 pol", {30'd0, active_pol_o}, 32'd3);
        chk_rd("R6 go cleared", 3'd5, ctrl_word(0, 0, 1, 2'd3));

        // R7 neither mode
        wr(3'd5, ctrl_word(1, 0, 0, 2'd0));
        chk_rd("R7 busy", 3'd5, ctrl_word(1, 0, 0, 2'd0));
        tick(S);
        chk_rd("R7 go cleared", 3'd5, ctrl_word(0, 0, 0, 2'd0));
        check("R7 no copy", clk_en_o, m_mask[3]);
        check("R7 pol kept", {30'd0, active_pol_o}, 32'd3);

        // R8 whole-word write, junk bits dropped
        wr(3'd5, 32'hFFFF_FEF8);
        chk_rd("R8 whole write", 3'd5, ctrl_word(0, 0, 0, 2'd2));
        check("R8 no commit", clk_en_o, m_mask[3]);

        // R10 stop during a sync commit
        wr(3'd5, ctrl_word(1, 1, 0, 2'd0));
        check("R5 sync pol0", clk_en_o, m_mask[0]);
        wr(3'd6, 32'h1);
        chk_rd("R10 held", 3'd6, stop_word(1, 1));
        tick(S - 2);
        chk_rd("R10 held last busy", 3'd6, stop_word(1, 1));
        tick(1);
        chk_rd("R10 go cleared", 3'd5, ctrl_word(0, 1, 0, 2'd0));
        chk_rd("R10 still pending", 3'd6, stop_word(1, 1));
        tick(1);
        chk_rd("R10 stopped after go", 3'd6, stop_word(0, 0));

        // R9 mask write accepted when stopped, output unchanged
        wr(3'd1, 32'hDEAD_0000);
        chk_rd("R9 stopped write", 3'd1, 32'hDEAD_0000);
        check("R9 clk_en held", clk_en_o, m_mask[0]);

        // R2 close then R3 ignored
        wr(3'd0, key_word(0));
        chk_rd("R2 closed", 3'd0, 32'h0);
        wr(3'd1, 32'h0000_BEEF);
        chk_rd("R3 closed mask", 3'd1, 32'hDEAD_0000);
        chk_rd("R11 unmapped end", 3'd7, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule